// File: doc/BRIEF.md
# Flag-Computing Integer ALU

This block is a purely combinational arithmetic and logic unit for a processor datapath that works on either byte-wide or word-wide operands. Each evaluation takes two operands, a width select, a four-bit operation code and the current status flags. It returns a result, a write enable that tells the register file whether to store that result, an upper result half used only by the multiplies, and the new status flags.

The supported operations are addition with and without carry in, subtraction with and without borrow in, increment, decrement, two's-complement negate, compare, the bitwise AND/OR/XOR, a non-storing AND test, bitwise invert, and unsigned and signed multiply. Each operation decides for itself which flags it recomputes and which it passes through. The caller does not need to know which flags a given operation touches.

The word width is a parameter, and the byte width is half of it. Byte operations look only at the low half of each operand. They return their results zero-extended to the full width.

Top module: `flagAlu`

## Requirements
- R1: Opcodes 0 (add) and 1 (add with carry) return (A + B + cin) modulo 2^n, where cin is flagsIn bit 0 for opcode 1 and 0 for opcode 0, and n is 8 or 16. CF is the carry out of the top bit, AF is the carry out of bit 3, and OF is set when the signed sum does not fit in n bits.
- R2: Opcodes 2 (subtract), 3 (subtract with borrow) and 7 (compare) return (A - B - bin) modulo 2^n, where bin is flagsIn bit 0 for opcode 3 and 0 otherwise. CF is set on a borrow, AF on a borrow out of bit 3, and OF when A and B have different signs and the result's sign differs from A.
- R3: Opcode 4 (increment) returns A + 1 and opcode 5 (decrement) returns A - 1, with AF, OF, PF, SF and ZF updated as for add or subtract of 1. CF is copied unchanged from flagsIn, so all ones plus one gives zero and leaves CF as it was.
- R4: Opcode 6 (negate) returns 0 - A with all six flags set as for that subtraction. CF is therefore set for every nonzero A.
- R5: Opcodes 8 (AND), 9 (OR), 10 (XOR) and 11 (test, an AND) clear CF, OF and AF, and update PF, SF and ZF from the result.
- R6: writeEn is 0 for compare (7) and test (11), and 1 for opcodes 0 through 14 otherwise. The result port still carries the difference for compare and the AND for test.
- R7: Opcode 12 returns the bitwise inverse of A within the selected width, and flagsOut equals flagsIn.
- R8: flagsOut bit positions are 0 CF, 1 PF, 2 AF, 3 ZF, 4 SF, 5 OF. For every flag-updating opcode: PF is 1 when the low 8 bits of the result hold an even number of ones, ZF is 1 when the result is zero within the width, and SF is the result's top bit within the width.
- R9: Opcode 13 (unsigned multiply) forms the 2n-bit product. The low n bits go on result and the high n bits on resultHigh. CF = OF = 1 exactly when the high half is nonzero, AF = 0, and SF, ZF and PF come from the low half.
- R10: Opcode 14 (signed multiply) forms the signed 2n-bit product, split as in R9. CF = OF = 0 when the high half is only copies of the low half's top bit, and 1 otherwise. The other flags are set as in R9.
- R11: With wordMode = 0, only bits 7:0 of each operand are used, bits 15:8 of result and resultHigh are 0, and flags are taken at byte width.
- R12: Opcode 15 is reserved. It gives writeEn 0, result 0, resultHigh 0, and flagsOut equal to flagsIn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | W | First operand (minuend, multiplicand, negate/invert source) |
| opB | input | W | Second operand |
| wordMode | input | 1 | 1 selects word width, 0 selects byte width |
| opcode | input | 4 | Operation code as listed in the requirements |
| flagsIn | input | 6 | Current status flags, bit layout as in R8 |
| result | output | W | Primary result (low half for multiplies) |
| resultHigh | output | W | Upper product half, 0 for non-multiplies |
| writeEn | output | 1 | Result should be written back |
| flagsOut | output | 6 | Updated status flags |

## Verification
The block holds no state, so a wrong decode strobe or a bad carry chain shows up at the ports in the same evaluation as the stimulus. No later cycle can hide or delay it. A mis-steered strobe usually shows up as a wrong flag rather than a wrong result: an increment that lets the carry through, a logic operation that keeps an overflow, or a compare that raises writeEn. For that reason every vector compares all four outputs together. A byte-mode slip leaks operand upper bits into the result or takes flags from the wrong bit, and that is visible whenever the unused operand bits are nonzero.

// File: rtl/flagAluPkg.sv
package flagAluPkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_CMP  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_TEST = 4'd11,
    OP_NOT  = 4'd12,
    OP_MUL  = 4'd13,
    OP_IMUL = 4'd14,
    OP_RSVD = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_OR  = 2'd1,
    LOG_XOR = 2'd2
  } logicSel_e;

  // bit 5 down to bit 0
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } aluFlags_t;

  typedef struct packed {
    logic      arith;
    logic      subtract;
    logic      useCarry;
    logic      bIsOne;
    logic      aIsZero;
    logic      keepCf;
    logic      logicOp;
    logicSel_e logicSel;
    logic      invertOnly;
    logic      mulOp;
    logic      mulSigned;
    logic      flagsHold;
    logic      writeRes;
  } ctrlStrobes_t;

endpackage

// File: rtl/flagAluCtrl.sv
module flagAluCtrl
  import flagAluPkg::*;
(
  input  logic [3:0]   opcode,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.logicSel = LOG_AND;
    strobes.writeRes = 1'b1;
    case (aluOp_e'(opcode))
      OP_ADD:  strobes.arith = 1'b1;
      OP_ADC: begin
        strobes.arith    = 1'b1;
        strobes.useCarry = 1'b1;
      end
      OP_SUB: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
      end
      OP_SBB: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
        strobes.useCarry = 1'b1;
      end
      OP_INC: begin
        strobes.arith  = 1'b1;
        strobes.bIsOne = 1'b1;
        strobes.keepCf = 1'b1;
      end
      OP_DEC: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
        strobes.bIsOne   = 1'b1;
        strobes.keepCf   = 1'b1;
      end
      OP_NEG: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
        strobes.aIsZero  = 1'b1;
      end
      OP_CMP: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
        strobes.writeRes = 1'b0;
      end
      OP_AND:  strobes.logicOp = 1'b1;
      OP_OR: begin
        strobes.logicOp  = 1'b1;
        strobes.logicSel = LOG_OR;
      end
      OP_XOR: begin
        strobes.logicOp  = 1'b1;
        strobes.logicSel = LOG_XOR;
      end
      OP_TEST: begin
        strobes.logicOp  = 1'b1;
        strobes.writeRes = 1'b0;
      end
      OP_NOT: begin
        strobes.invertOnly = 1'b1;
        strobes.flagsHold  = 1'b1;
      end
      OP_MUL:  strobes.mulOp = 1'b1;
      OP_IMUL: begin
        strobes.mulOp     = 1'b1;
        strobes.mulSigned = 1'b1;
      end
      default: begin
        strobes.flagsHold = 1'b1;
        strobes.writeRes  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/flagAluDatapath.sv
module flagAluDatapath
  import flagAluPkg::*;
#(
  parameter int W = 16
) (
  input  ctrlStrobes_t strobes,
  input  logic         wordMode,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  aluFlags_t    flagsIn,
  output logic [W-1:0] result,
  output logic [W-1:0] resultHigh,
  output aluFlags_t    flagsOut
);

  localparam int H  = W / 2;
  localparam int PW = 8;

  logic [W-1:0]   aIn, bIn;
  logic [W-1:0]   addA, addB, bEff;
  logic           cIn, c0, cOut, carry;
  logic [W:0]     sumW;
  logic [H:0]     sumH;
  logic [W-1:0]   addRes;
  logic           auxCarry, ovf;
  logic           aMsb, bMsb, rMsb;
  logic [W-1:0]   logicRes;
  logic [2*W-1:0] mulA, mulB, prod;
  logic [W-1:0]   mulLo, mulHi;
  logic           hiSignificant;
  logic [W-1:0]   res;
  logic           resSign, resZero, resParity;

  // operand width masking
  always_comb begin
    aIn = wordMode ? opA : {{(W-H){1'b0}}, opA[H-1:0]};
    bIn = wordMode ? opB : {{(W-H){1'b0}}, opB[H-1:0]};
  end

  // shared adder / subtractor
  always_comb begin
    addA   = strobes.aIsZero ? '0 : aIn;
    addB   = strobes.aIsZero ? aIn : (strobes.bIsOne ? W'(1) : bIn);
    bEff   = strobes.subtract ? ~addB : addB;
    cIn    = strobes.useCarry & flagsIn.cf;
    c0     = strobes.subtract ^ cIn;
    sumW   = {1'b0, addA} + {1'b0, bEff} + (W+1)'(c0);
    sumH   = {1'b0, addA[H-1:0]} + {1'b0, bEff[H-1:0]} + (H+1)'(c0);
    addRes = wordMode ? sumW[W-1:0] : {{(W-H){1'b0}}, sumH[H-1:0]};
    cOut   = wordMode ? sumW[W] : sumH[H];
    carry  = strobes.subtract ^ cOut;
    auxCarry = addA[4] ^ addB[4] ^ addRes[4];
    aMsb   = wordMode ? addA[W-1]   : addA[H-1];
    bMsb   = wordMode ? bEff[W-1]   : bEff[H-1];
    rMsb   = wordMode ? addRes[W-1] : addRes[H-1];
    ovf    = (aMsb == bMsb) && (rMsb != aMsb);
  end

  // bitwise unit
  always_comb begin
    case (strobes.logicSel)
      LOG_OR:  logicRes = aIn | bIn;
      LOG_XOR: logicRes = aIn ^ bIn;
      default: logicRes = aIn & bIn;
    endcase
  end

  // multiplier: operands extended to 2W, product kept to 2W bits
  always_comb begin
    if (!strobes.mulSigned) begin
      mulA = {{W{1'b0}}, aIn};
      mulB = {{W{1'b0}}, bIn};
    end else if (wordMode) begin
      mulA = {{W{aIn[W-1]}}, aIn};
      mulB = {{W{bIn[W-1]}}, bIn};
    end else begin
      mulA = {{(2*W-H){aIn[H-1]}}, aIn[H-1:0]};
      mulB = {{(2*W-H){bIn[H-1]}}, bIn[H-1:0]};
    end
    prod  = mulA * mulB;
    mulLo = wordMode ? prod[W-1:0]   : {{(W-H){1'b0}}, prod[H-1:0]};
    mulHi = wordMode ? prod[2*W-1:W] : {{(W-H){1'b0}}, prod[W-1:H]};
    if (!strobes.mulSigned)
      hiSignificant = (mulHi != '0);
    else if (wordMode)
      hiSignificant = (mulHi != {W{mulLo[W-1]}});
    else
      hiSignificant = (mulHi[H-1:0] != {H{mulLo[H-1]}});
  end

  // result select
  always_comb begin
    if (strobes.arith)           res = addRes;
    else if (strobes.logicOp)    res = logicRes;
    else if (strobes.invertOnly) res = wordMode ? ~aIn : {{(W-H){1'b0}}, ~aIn[H-1:0]};
    else if (strobes.mulOp)      res = mulLo;
    else                         res = '0;
    result     = res;
    resultHigh = strobes.mulOp ? mulHi : '0;
  end

  // flag generation
  always_comb begin
    resSign   = wordMode ? res[W-1] : res[H-1];
    resZero   = (res == '0);
    resParity = ~^res[PW-1:0];
    flagsOut  = flagsIn;
    if (!strobes.flagsHold) begin
      flagsOut.pf = resParity;
      flagsOut.sf = resSign;
      flagsOut.zf = resZero;
      if (strobes.arith) begin
        flagsOut.cf = strobes.keepCf ? flagsIn.cf : carry;
        flagsOut.af = auxCarry;
        flagsOut.of = ovf;
      end else if (strobes.mulOp) begin
        flagsOut.cf = hiSignificant;
        flagsOut.of = hiSignificant;
        flagsOut.af = 1'b0;
      end else begin
        flagsOut.cf = 1'b0;
        flagsOut.of = 1'b0;
        flagsOut.af = 1'b0;
      end
    end
  end

endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import flagAluPkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         wordMode,
  input  logic [3:0]   opcode,
  input  logic [5:0]   flagsIn,
  output logic [W-1:0] result,
  output logic [W-1:0] resultHigh,
  output logic         writeEn,
  output logic [5:0]   flagsOut
);

  ctrlStrobes_t strobes;
  aluFlags_t    flagsNew;

  flagAluCtrl uCtrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  flagAluDatapath #(.W(W)) uData (
    .strobes    (strobes),
    .wordMode   (wordMode),
    .opA        (opA),
    .opB        (opB),
    .flagsIn    (aluFlags_t'(flagsIn)),
    .result     (result),
    .resultHigh (resultHigh),
    .flagsOut   (flagsNew)
  );

  assign writeEn  = strobes.writeRes;
  assign flagsOut = flagsNew;

endmodule

// File: rtl/flagAluChecker.sv
module flagAluChecker
  import flagAluPkg::*;
#(
  parameter int W = 16
) (
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic         wordMode,
  input logic [3:0]   opcode,
  input logic [5:0]   flagsIn,
  input logic [W-1:0] result,
  input logic [W-1:0] resultHigh,
  input logic         writeEn,
  input logic [5:0]   flagsOut
);

  localparam int H = W / 2;

  logic known;
  logic [W-1:0] invExp;

  always_comb begin
    known  = !$isunknown({opA, opB, wordMode, opcode, flagsIn});
    invExp = wordMode ? ~opA : {{(W-H){1'b0}}, ~opA[H-1:0]};
    if (known) begin
      // R3
      incdec_keep_cf_chk: assert (!(opcode == OP_INC || opcode == OP_DEC) ||
                                  flagsOut[0] == flagsIn[0]);
      // R5
      logic_clear_cf_of_chk: assert (!(opcode >= OP_AND && opcode <= OP_TEST) ||
                                     (flagsOut[0] == 1'b0 && flagsOut[5] == 1'b0));
      // R6
      no_store_on_compare_chk: assert (!(opcode == OP_CMP || opcode == OP_TEST) ||
                                       !writeEn);
      // R7
      invert_flags_hold_chk: assert (opcode != OP_NOT ||
                                     (flagsOut == flagsIn && result == invExp));
      // R8
      parity_low_byte_chk: assert (opcode == OP_NOT || opcode == OP_RSVD ||
                                   flagsOut[1] == ~^result[7:0]);
      // R11
      byte_upper_zero_chk: assert (wordMode ||
                                   (result[W-1:H] == '0 && resultHigh[W-1:H] == '0));
      // R12
      reserved_inert_chk: assert (opcode != OP_RSVD ||
                                  (!writeEn && flagsOut == flagsIn && result == '0));
    end
  end

endmodule

bind flagAlu flagAluChecker #(.W(W)) uChk (
  .opA        (opA),
  .opB        (opB),
  .wordMode   (wordMode),
  .opcode     (opcode),
  .flagsIn    (flagsIn),
  .result     (result),
  .resultHigh (resultHigh),
  .writeEn    (writeEn),
  .flagsOut   (flagsOut)
);

// File: tb/sim_flagAlu.sv
`timescale 1ns/1ps
module sim_flagAlu;

  logic        clk = 1'b0;
  logic [15:0] opA, opB;
  logic        wordMode;
  logic [3:0]  opcode;
  logic [5:0]  flagsIn;
  logic [15:0] result, resultHigh;
  logic        writeEn;
  logic [5:0]  flagsOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2.5 clk = ~clk;

  flagAlu #(.W(16)) u0 (
    .opA(opA), .opB(opB), .wordMode(wordMode), .opcode(opcode),
    .flagsIn(flagsIn), .result(result), .resultHigh(resultHigh),
    .writeEn(writeEn), .flagsOut(flagsOut)
  );

  function automatic longint sext(input longint v, input longint n);
    return (v >= (longint'(1) << (n-1))) ? v - (longint'(1) << n) : v;
  endfunction

  function automatic logic evenParity(input longint v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'((v >> i) & 1);
    return (ones % 2) == 0;
  endfunction

  function automatic string reqTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R1";
      4'd2, 4'd3:        return "R2";
      4'd4, 4'd5:        return "R3";
      4'd6:              return "R4";
      4'd7, 4'd11:       return "R6";
      4'd8, 4'd9, 4'd10: return "R5";
      4'd12:             return "R7";
      4'd13:             return "R9";
      4'd14:             return "R10";
      default:           return "R12";
    endcase
  endfunction

  // independent arithmetic model; flags {of,sf,zf,af,pf,cf}
  task automatic model(input logic [15:0] a0, input logic [15:0] b0, input logic w,
                       input logic [3:0] op, input logic [5:0] fi,
                       output logic [15:0] r, output logic [15:0] h,
                       output logic we, output logic [5:0] fo);
    longint n = w ? 16 : 8;
    longint m = (longint'(1) << n) - 1;
    longint maxS = (longint'(1) << (n-1)) - 1;
    longint minS = -(longint'(1) << (n-1));
    longint a = longint'(a0) & m;
    longint b = longint'(b0) & m;
    longint ci = longint'(fi[0]);
    longint ua = 0, ub = 0, cc = 0, s = 0, x = 0, p = 0, res = 0, hi = 0;
    logic cf = 0, af = 0, of = 0;
    int kind; // 0 add, 1 sub, 2 logic, 3 not, 4 mul, 5 imul, 6 reserved
    logic keep = 0;
    we = 1'b1;
    case (op)
      4'd0:  begin kind = 0; ua = a; ub = b; end
      4'd1:  begin kind = 0; ua = a; ub = b; cc = ci; end
      4'd2:  begin kind = 1; ua = a; ub = b; end
      4'd3:  begin kind = 1; ua = a; ub = b; cc = ci; end
      4'd4:  begin kind = 0; ua = a; ub = 1; keep = 1; end
      4'd5:  begin kind = 1; ua = a; ub = 1; keep = 1; end
      4'd6:  begin kind = 1; ua = 0; ub = a; end
      4'd7:  begin kind = 1; ua = a; ub = b; we = 0; end
      4'd8:  begin kind = 2; res = a & b; end
      4'd9:  begin kind = 2; res = a | b; end
      4'd10: begin kind = 2; res = a ^ b; end
      4'd11: begin kind = 2; res = a & b; we = 0; end
      4'd12: begin kind = 3; res = (~a) & m; end
      4'd13: kind = 4;
      4'd14: kind = 5;
      default: begin kind = 6; we = 0; end
    endcase
    if (kind == 0) begin
      s = ua + ub + cc; res = s & m; cf = ((s >> n) & 1) != 0;
      af = ((ua & 15) + (ub & 15) + cc) > 15;
      x = sext(ua, n) + sext(ub, n) + cc; of = (x > maxS) || (x < minS);
    end else if (kind == 1) begin
      s = ua - ub - cc; res = s & m; cf = s < 0;
      af = (ua & 15) < ((ub & 15) + cc);
      x = sext(ua, n) - sext(ub, n) - cc; of = (x > maxS) || (x < minS);
    end else if (kind == 4) begin
      p = a * b; res = p & m; hi = (p >> n) & m;
      cf = hi != 0; of = cf;
    end else if (kind == 5) begin
      p = sext(a, n) * sext(b, n); res = p & m; hi = (p >>> n) & m;
      cf = (p > maxS) || (p < minS); of = cf;
    end
    if (keep) cf = fi[0];
    r = 16'(res);
    h = 16'(hi);
    if (kind == 3 || kind == 6)
      fo = fi;
    else
      fo = {of, ((res >> (n-1)) & 1) != 0, res == 0, af, evenParity(res), cf};
  endtask

  task automatic applyCheck(input logic [15:0] a, input logic [15:0] b, input logic w,
                            input logic [3:0] op, input logic [5:0] fi);
    logic [15:0] er, eh;
    logic ewe;
    logic [5:0] ef;
    string tag;
    opA = a; opB = b; wordMode = w; opcode = op; flagsIn = fi;
    #1;
    model(a, b, w, op, fi, er, eh, ewe, ef);
    checkCount++;
    if (result !== er || resultHigh !== eh || writeEn !== ewe || flagsOut !== ef) begin
      failCount++;
      tag = reqTag(op);
      if (flagsOut !== ef) tag = {tag, " R8"};
      if (!w) tag = {tag, " R11"};
      $display("FAIL %s op=%0d w=%0b a=%h b=%h fi=%h got r=%h h=%h we=%b f=%h exp r=%h h=%h we=%b f=%h",
               tag, op, w, a, b, fi, result, resultHigh, writeEn, flagsOut, er, eh, ewe, ef);
    end
  endtask

  task automatic checkLit(input string tag, input logic [47:0] actual, input logic [47:0] expected);
    checkCount++;
    if (actual !== expected) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
    end
  endtask

  function automatic logic [15:0] pick(input int i);
    logic [15:0] tbl [16] = '{16'h0000, 16'h0001, 16'h0002, 16'h000F, 16'h0010, 16'h007F,
                              16'h0080, 16'h00FF, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFE,
                              16'hFFFF, 16'h1234, 16'h5A5A, 16'hC3C3};
    return tbl[i];
  endfunction

  function automatic logic [7:0] pickByte(input int i);
    logic [7:0] tbl [16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'h81,
                             8'hFE, 8'hFF, 8'h55, 8'hAA, 8'h33, 8'hC8, 8'h07, 8'hF0};
    return tbl[i];
  endfunction

  initial begin
    #150000;
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired before the run completed");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    opA = '0; opB = '0; wordMode = 1'b1; opcode = 4'd15; flagsIn = 6'h15;
    #3;
    // R12 idle reserved state: nothing written, flags pass
    checkLit("R12 idle", {result, resultHigh, writeEn, flagsOut, 9'd0},
             {16'h0000, 16'h0000, 1'b0, 6'h15, 9'd0});

    // R3 all ones plus one, CF held at 1
    opA = 16'hFFFF; opB = 16'h0; wordMode = 1; opcode = 4'd4; flagsIn = 6'h01; #1;
    checkLit("R3 inc wrap", {result, writeEn, flagsOut, 25'd0}, {16'h0000, 1'b1, 6'h0F, 25'd0});
    // R3 same with CF held at 0
    flagsIn = 6'h00; #1;
    checkLit("R3 inc wrap cf0", {result, flagsOut, 26'd0}, {16'h0000, 6'h0E, 26'd0});
    // R10 byte signed multiply -128*2
    opA = 16'hEE80; opB = 16'h3302; wordMode = 0; opcode = 4'd14; flagsIn = 6'h00; #1;
    checkLit("R10 imul byte", {result, resultHigh, flagsOut, 10'd0}, {16'h0000, 16'h00FF, 6'h2B, 10'd0});
    // R9 word unsigned multiply FFFF*FFFF
    opA = 16'hFFFF; opB = 16'hFFFF; wordMode = 1; opcode = 4'd13; #1;
    checkLit("R9 mul word", {result, resultHigh, flagsOut, 10'd0}, {16'h0001, 16'hFFFE, 6'h21, 10'd0});
    // R2 byte 0x80-0x01 signed overflow
    opA = 16'h0080; opB = 16'h0001; wordMode = 0; opcode = 4'd2; #1;
    checkLit("R2 sub ovf", {result, flagsOut, 26'd0}, {16'h007F, 6'h24, 26'd0});
    // R7 invert keeps flags
    opA = 16'h0F0F; wordMode = 1; opcode = 4'd12; flagsIn = 6'h2A; #1;
    checkLit("R7 not", {result, writeEn, flagsOut, 25'd0}, {16'hF0F0, 1'b1, 6'h2A, 25'd0});
    // R6 test does not store
    opA = 16'h00F0; opB = 16'h000F; opcode = 4'd11; flagsIn = 6'h3F; #1;
    checkLit("R6 test", {result, writeEn, flagsOut, 25'd0}, {16'h0000, 1'b0, 6'h0A, 25'd0});
    // R4 negate of 1 in word width
    opA = 16'h0001; opcode = 4'd6; flagsIn = 6'h00; #1;
    checkLit("R4 neg", {result, flagsOut, 26'd0}, {16'hFFFF, 6'h17, 26'd0});

    // byte sweep with garbage in upper operand bits (R11)
    for (int a = 0; a < 256; a++)
      for (int bi = 0; bi < 16; bi++)
        for (int op = 0; op < 16; op++)
          applyCheck({8'hA5, 8'(a)}, {8'h5A, pickByte(bi)}, 1'b0, 4'(op),
                     6'(a ^ (bi * 7) ^ op));

    // word corner sweep, both incoming carry values
    for (int ai = 0; ai < 16; ai++)
      for (int bi = 0; bi < 16; bi++)
        for (int op = 0; op < 16; op++)
          for (int c = 0; c < 2; c++)
            applyCheck(pick(ai), pick(bi), 1'b1, 4'(op), 6'((ai << 1) ^ bi) ^ 6'(c));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule